// File: doc/BRIEF.md
# Atomic Micro-op Block Former

This unit sits between instruction fetch and block dispatch in a core that executes code as atomic blocks. Fetched micro-ops arrive one per cycle and are collected in a block buffer. When the first micro-op of a block arrives, a metadata lookup keyed by start PC and branch path has already resolved, and its outcome comes in with that micro-op as a hit flag, a learned block length and a learned execution mode. The unit decides on which micro-op the block closes. It then presents the finished block, with its start PC, length, per-slot taken-branch path, payloads, hit flag, execution mode and the reason it closed, as a one-cycle pulse.

When the metadata lookup hits, the learned length alone sets the end of the block. When it misses, the block closes on the first of three conditions: an indirect branch, a conditional branch that a table of saturating counters marks as hard to predict, or a full buffer. A miss block always carries the default out-of-order mode, because that mode needs no precomputed information. The counter table is trained by branch resolution updates: a mispredict moves a counter up and a correct prediction moves it down.

The control is a three-state machine. ST_IDLE has no block open. ST_GATHER_MISS and ST_GATHER_HIT hold an open block whose first micro-op missed or hit. The START transition leaves ST_IDLE for one of the gather states when a micro-op arrives and does not close the block. The CLOSE transition returns from either gather state to ST_IDLE on the closing micro-op. The IMMEDIATE case stays in ST_IDLE when the first micro-op also closes its block.

Top module: `blk_former`

## Requirements
- R1: A miss block holds at most 16 micro-ops. The 16th micro-op closes it with cause code 0 (full) unless a higher-priority cause applies. Every emitted block has a length from 1 to 16.
- R2: In a miss block, a micro-op of kind 2 (indirect branch) closes the block as its last entry with cause code 1. This cause takes priority over hard branch and full.
- R3: In a miss block, a micro-op of kind 1 (conditional branch) whose counter is 2 or more closes the block as its last entry with cause code 2. A conditional branch with a counter below 2, and micro-ops of kind 0 (plain) and kind 3 (direct jump), never close a miss block early.
- R4: The hardness table has 1024 two-bit counters selected by PC bits [11:2], all zero after reset. An update with the mispredict flag set increments the selected counter and saturates at 3.
- R5: An update with the mispredict flag clear decrements the selected counter and saturates at 0, so a branch can lose its hard status.
- R6: A miss block is emitted with the hit flag at 0 and mode 0 (out-of-order).
- R7: For a hit block, meta_hit, meta_len and meta_mode are sampled on the first micro-op only. The block closes exactly at the learned length, and a learned length of 0 or above 16 counts as 16. Indirect and hard branches do not close it. It is emitted with the hit flag at 1, the learned mode and cause code 3.
- R8: The block output pulses for exactly one cycle, in the cycle after the closing micro-op is accepted. blk_pc is the PC of the first micro-op. Slot i of blk_uops (slot 0 at the least significant end) holds the payload of the i-th micro-op, and slots at or beyond the length are zero. A micro-op in the next cycle starts a new block.
- R9: Bit i of blk_path is the taken flag of micro-op i if that micro-op is a conditional branch, and 0 otherwise.
- R10: After reset no block is open and blk_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A micro-op is presented this cycle |
| in_pc | input | 32 | PC of the micro-op |
| in_kind | input | 2 | 0 plain, 1 conditional, 2 indirect, 3 direct jump |
| in_taken | input | 1 | Predicted direction of a conditional branch |
| in_pay | input | 16 | Opaque micro-op payload |
| meta_hit | input | 1 | Metadata lookup hit, taken on the first micro-op |
| meta_len | input | 5 | Learned block length on a hit |
| meta_mode | input | 2 | Learned execution mode on a hit |
| upd_valid | input | 1 | Branch resolution update strobe |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_miss | input | 1 | 1 = mispredicted, 0 = predicted correctly |
| blk_valid | output | 1 | Finished block pulse |
| blk_pc | output | 32 | Start PC of the block |
| blk_len | output | 5 | Micro-op count |
| blk_hit | output | 1 | Block formed under a metadata hit |
| blk_mode | output | 2 | Execution mode (0 = out-of-order) |
| blk_cause | output | 2 | 0 full, 1 indirect, 2 hard branch, 3 learned length |
| blk_path | output | 16 | Per-slot taken-branch bits |
| blk_uops | output | 256 | Per-slot payloads |

## Verification
The bench sweeps the position of an indirect branch across all sixteen slots, including slot 16. A design with the wrong cause priority there would report the block as full, and an off-by-one end check would emit blocks of 17 or 15. It walks one branch counter through every value, both up and down past the saturation points, and checks hardness after each update. A counter that wraps instead of saturating shows up as a branch that flips hard or easy at the wrong moment. A PC that differs only in bit 12 must share the same counter, while a neighbouring word must not, which exposes a wrong index slice. It also sweeps the learned lengths 0 to 17 with indirect and hard branches inside the block, to catch a hit block that closes early or fails to clamp its length.

// File: rtl/blk_former_pkg.sv
package blk_former_pkg;

    typedef enum logic [1:0] {
        UOP_PLAIN  = 2'd0,
        UOP_COND   = 2'd1,
        UOP_INDIR  = 2'd2,
        UOP_DIRECT = 2'd3
    } uop_kind_e;

    typedef enum logic [1:0] {
        END_FULL  = 2'd0,
        END_INDIR = 2'd1,
        END_HARD  = 2'd2,
        END_META  = 2'd3
    } end_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_GATHER_MISS = 2'd1,
        ST_GATHER_HIT  = 2'd2
    } bf_state_e;

endpackage

// File: rtl/bf_hard_table.sv
module bf_hard_table #(
    parameter int ENTRIES = 1024,
    parameter int CTR_W   = 2,
    parameter int HARD_AT = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_hard,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_miss
);
    localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

    logic [CTR_W-1:0] ctr [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ctr[i] <= '0;
            end
        end else if (upd_valid) begin
            if (upd_miss && ctr[upd_idx] != CTR_MAX) begin
                ctr[upd_idx] <= ctr[upd_idx] + 1'b1;
            end else if (!upd_miss && ctr[upd_idx] != '0) begin
                ctr[upd_idx] <= ctr[upd_idx] - 1'b1;
            end
        end
    end

    assign look_hard = (ctr[look_idx] >= CTR_W'(HARD_AT));

    // R4: saturation at the top
    p_ctr_sat_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_miss && ctr[upd_idx] == CTR_MAX)
        |=> (ctr[$past(upd_idx)] == CTR_MAX));

    // R5: a correct prediction never moves a counter below zero
    p_ctr_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_miss && ctr[upd_idx] == '0)
        |=> (ctr[$past(upd_idx)] == '0));

endmodule

// File: rtl/bf_block_buffer.sv
module bf_block_buffer #(
    parameter int DEPTH  = 16,
    parameter int PAY_W  = 16,
    localparam int CNT_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CNT_W-1:0]       wr_slot,
    input  logic [PAY_W-1:0]       wr_pay,
    input  logic                   wr_path,
    output logic [DEPTH*PAY_W-1:0] snap_pay,
    output logic [DEPTH-1:0]       snap_path
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [CNT_W-1:0] SLOT = CNT_W'(g);
        logic [PAY_W-1:0] pay_q;
        logic             path_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pay_q  <= '0;
                path_q <= 1'b0;
            end else if (wr_en && wr_slot == SLOT) begin
                pay_q  <= wr_pay;
                path_q <= wr_path;
            end
        end

        // merged view: held slots, the arriving slot, zero beyond
        always_comb begin
            if (wr_slot == SLOT) begin
                snap_pay[g*PAY_W +: PAY_W] = wr_pay;
                snap_path[g]               = wr_path;
            end else if (SLOT < wr_slot) begin
                snap_pay[g*PAY_W +: PAY_W] = pay_q;
                snap_path[g]               = path_q;
            end else begin
                snap_pay[g*PAY_W +: PAY_W] = '0;
                snap_path[g]               = 1'b0;
            end
        end
    end

endmodule

// File: rtl/blk_former.sv
module blk_former
    import blk_former_pkg::*;
#(
    parameter int MAX_UOPS    = 16,
    parameter int PAY_W       = 16,
    parameter int PC_W        = 32,
    parameter int TBL_ENTRIES = 1024,
    parameter int TBL_IDX_LO  = 2,
    parameter int HARD_AT     = 2,
    parameter int MODE_W      = 2,
    localparam int CNT_W      = $clog2(MAX_UOPS),
    localparam int LEN_W      = $clog2(MAX_UOPS + 1),
    localparam int IDX_W      = $clog2(TBL_ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [PC_W-1:0]           in_pc,
    input  logic [1:0]                in_kind,
    input  logic                      in_taken,
    input  logic [PAY_W-1:0]          in_pay,
    input  logic                      meta_hit,
    input  logic [LEN_W-1:0]          meta_len,
    input  logic [MODE_W-1:0]         meta_mode,
    input  logic                      upd_valid,
    input  logic [PC_W-1:0]           upd_pc,
    input  logic                      upd_miss,
    output logic                      blk_valid,
    output logic [PC_W-1:0]           blk_pc,
    output logic [LEN_W-1:0]          blk_len,
    output logic                      blk_hit,
    output logic [MODE_W-1:0]         blk_mode,
    output logic [1:0]                blk_cause,
    output logic [MAX_UOPS-1:0]       blk_path,
    output logic [MAX_UOPS*PAY_W-1:0] blk_uops
);
    localparam logic [LEN_W-1:0]  LEN_MAX  = LEN_W'(MAX_UOPS);
    localparam logic [MODE_W-1:0] MODE_OOO = '0;

    bf_state_e         state, nxt_state;
    logic [CNT_W-1:0]  cnt_q;
    logic [PC_W-1:0]   start_pc_q;
    logic [LEN_W-1:0]  lim_q;
    logic [MODE_W-1:0] mode_q;

    uop_kind_e         kind;
    logic              first, cur_hit, is_cond, is_ind, look_hard, hard_c;
    logic [CNT_W-1:0]  slot;
    logic [LEN_W-1:0]  pos_len, meta_lim, cur_lim;
    logic [MODE_W-1:0] cur_mode;
    logic              closes;
    end_cause_e        cause;
    logic [MAX_UOPS*PAY_W-1:0] snap_pay;
    logic [MAX_UOPS-1:0]       snap_path;

    assign kind     = uop_kind_e'(in_kind);
    assign is_cond  = (kind == UOP_COND);
    assign is_ind   = (kind == UOP_INDIR);
    assign first    = (state == ST_IDLE);
    assign cur_hit  = first ? meta_hit : (state == ST_GATHER_HIT);
    assign meta_lim = (meta_len == '0 || meta_len > LEN_MAX) ? LEN_MAX : meta_len;
    assign cur_lim  = first ? meta_lim : lim_q;
    assign cur_mode = !cur_hit ? MODE_OOO : (first ? meta_mode : mode_q);
    assign slot     = first ? '0 : cnt_q;
    assign pos_len  = LEN_W'(slot) + 1'b1;
    assign hard_c   = is_cond && look_hard;

    bf_hard_table #(
        .ENTRIES (TBL_ENTRIES),
        .CTR_W   (2),
        .HARD_AT (HARD_AT)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_idx  (in_pc[TBL_IDX_LO +: IDX_W]),
        .look_hard (look_hard),
        .upd_valid (upd_valid),
        .upd_idx   (upd_pc[TBL_IDX_LO +: IDX_W]),
        .upd_miss  (upd_miss)
    );

    bf_block_buffer #(
        .DEPTH (MAX_UOPS),
        .PAY_W (PAY_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_valid),
        .wr_slot   (slot),
        .wr_pay    (in_pay),
        .wr_path   (is_cond && in_taken),
        .snap_pay  (snap_pay),
        .snap_path (snap_path)
    );

    // end detection, priority indirect > hard > full on a miss
    always_comb begin
        cause  = END_FULL;
        closes = 1'b0;
        if (in_valid) begin
            if (cur_hit) begin
                cause  = END_META;
                closes = (pos_len == cur_lim);
            end else if (is_ind) begin
                cause  = END_INDIR;
                closes = 1'b1;
            end else if (hard_c) begin
                cause  = END_HARD;
                closes = 1'b1;
            end else begin
                cause  = END_FULL;
                closes = (pos_len == LEN_MAX);
            end
        end
    end

    // next state
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (in_valid && !closes) begin
                    nxt_state = meta_hit ? ST_GATHER_HIT : ST_GATHER_MISS;
                end
            end
            ST_GATHER_MISS, ST_GATHER_HIT: begin
                if (closes) begin
                    nxt_state = ST_IDLE;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // state register and open-block context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt_q      <= '0;
            start_pc_q <= '0;
            lim_q      <= '0;
            mode_q     <= '0;
        end else begin
            state <= nxt_state;
            if (in_valid) begin
                cnt_q <= closes ? '0 : slot + 1'b1;
                if (first) begin
                    start_pc_q <= in_pc;
                    lim_q      <= meta_lim;
                    mode_q     <= meta_hit ? meta_mode : MODE_OOO;
                end
            end
        end
    end

    // block output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_valid <= 1'b0;
            blk_pc    <= '0;
            blk_len   <= '0;
            blk_hit   <= 1'b0;
            blk_mode  <= '0;
            blk_cause <= '0;
            blk_path  <= '0;
            blk_uops  <= '0;
        end else begin
            blk_valid <= closes;
            if (closes) begin
                blk_pc    <= first ? in_pc : start_pc_q;
                blk_len   <= pos_len;
                blk_hit   <= cur_hit;
                blk_mode  <= cur_mode;
                blk_cause <= cause;
                blk_path  <= snap_path;
                blk_uops  <= snap_pay;
            end
        end
    end

    // R1: emitted length in range
    p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (blk_len >= 1 && blk_len <= LEN_MAX));

    // R2: an indirect branch in a miss block closes it next cycle
    p_indir_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cur_hit && is_ind) |=> (blk_valid && blk_cause == END_INDIR));

    // R6: miss blocks run out-of-order and never report the learned length
    p_miss_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !blk_hit) |-> (blk_mode == MODE_OOO && blk_cause != END_META));

    // R7: hit blocks close only on the learned length
    p_hit_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_hit) |-> (blk_cause == END_META));

    // R8: a pulse always follows an accepted micro-op
    p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> $past(in_valid));

endmodule

// File: tb/blk_former_bench.sv
`timescale 1ns/1ps
module blk_former_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_pc = '0;
    logic [1:0]   in_kind = '0;
    logic         in_taken = 1'b0;
    logic [15:0]  in_pay = '0;
    logic         meta_hit = 1'b0;
    logic [4:0]   meta_len = '0;
    logic [1:0]   meta_mode = '0;
    logic         upd_valid = 1'b0;
    logic [31:0]  upd_pc = '0;
    logic         upd_miss = 1'b0;
    logic         blk_valid;
    logic [31:0]  blk_pc;
    logic [4:0]   blk_len;
    logic         blk_hit;
    logic [1:0]   blk_mode;
    logic [1:0]   blk_cause;
    logic [15:0]  blk_path;
    logic [255:0] blk_uops;

    always #2 clk = ~clk;

    blk_former u_blk_former (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
        .in_kind(in_kind), .in_taken(in_taken), .in_pay(in_pay),
        .meta_hit(meta_hit), .meta_len(meta_len), .meta_mode(meta_mode),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_miss(upd_miss),
        .blk_valid(blk_valid), .blk_pc(blk_pc), .blk_len(blk_len),
        .blk_hit(blk_hit), .blk_mode(blk_mode), .blk_cause(blk_cause),
        .blk_path(blk_path), .blk_uops(blk_uops)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;
    int tbl [1024];
    bit m_open = 0, m_hit = 0;
    int m_cnt = 0, m_lim = 0;
    logic [1:0] m_mode;
    logic [31:0] m_pc;
    logic [15:0] m_path;
    logic [255:0] m_pays;
    logic [15:0] seq = 16'h0101;
    localparam logic [31:0] HB = 32'h0000_2040;

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] pc, input logic [1:0] kind, input bit tk,
                        input bit hit, input logic [4:0] mlen, input logic [1:0] mode);
        logic [15:0] pay;
        bit term;
        int cause;
        string tag;
        pay = seq;
        seq = seq + 16'h0103;
        if (!m_open) begin
            m_open = 1; m_cnt = 0; m_pc = pc; m_hit = hit;
            m_lim  = (mlen == 0 || mlen > 16) ? 16 : int'(mlen);
            m_mode = hit ? mode : 2'd0;
            m_path = '0; m_pays = '0;
        end
        m_pays[m_cnt*16 +: 16] = pay;
        m_path[m_cnt] = (kind == 2'd1) && tk;
        m_cnt++;
        term = 0; cause = 0;
        if (m_hit) begin
            if (m_cnt == m_lim) begin term = 1; cause = 3; end
        end else if (kind == 2'd2) begin
            term = 1; cause = 1;
        end else if (kind == 2'd1 && tbl[pc[11:2]] >= 2) begin
            term = 1; cause = 2;
        end else if (m_cnt == 16) begin
            term = 1; cause = 0;
        end
        in_valid = 1; in_pc = pc; in_kind = kind; in_taken = tk; in_pay = pay;
        meta_hit = hit; meta_len = mlen; meta_mode = mode;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        case (cause)
            0: tag = "R1";
            1: tag = "R2";
            2: tag = "R3";
            default: tag = "R7";
        endcase
        if (!term) tag = m_hit ? "R7 no close" : "R3 no early close";
        chk(blk_valid == term, {tag, " pulse"}, blk_valid, term);
        if (term) begin
            chk(blk_pc == m_pc, "R8 start pc", blk_pc, m_pc);
            chk(int'(blk_len) == m_cnt, {tag, " length"}, blk_len, m_cnt);
            chk(int'(blk_cause) == cause, {tag, " cause"}, blk_cause, cause);
            chk(blk_hit == m_hit, "R6 hit flag", blk_hit, m_hit);
            chk(blk_mode == m_mode, m_hit ? "R7 mode" : "R6 mode", blk_mode, m_mode);
            chk(blk_path == m_path, "R9 path", blk_path, m_path);
            chk(blk_uops == m_pays, "R8 payloads", blk_uops, m_pays);
            m_open = 0;
        end
    endtask

    task automatic upd(input logic [31:0] pc, input bit miss);
        upd_valid = 1; upd_pc = pc; upd_miss = miss;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 0;
        if (miss && tbl[pc[11:2]] < 3) tbl[pc[11:2]]++;
        if (!miss && tbl[pc[11:2]] > 0) tbl[pc[11:2]]--;
    endtask

    // plain, conditional at pc, indirect: shows whether pc is hard (R4, R5)
    task automatic probe(input logic [31:0] pc, input bit tk);
        push(32'h4000_0000, 2'd0, 0, 0, 0, 0);
        push(pc, 2'd1, tk, 0, 0, 0);
        if (m_open) push(32'h4000_0100, 2'd2, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) tbl[i] = 0;
        repeat (3) @(negedge clk);
        chk(blk_valid == 0, "R10 reset pulse", blk_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk(blk_valid == 0, "R10 idle after reset", blk_valid, 0);

        // R1, R8: long plain stream, then an indirect closes the remainder
        for (int i = 0; i < 40; i++) push(32'h1000 + 32'(i*4), 2'd0, 0, 0, 0, 0);
        push(32'h1100, 2'd2, 0, 0, 0, 0);

        // R2: indirect at every slot position 1..16
        for (int k = 1; k <= 16; k++) begin
            for (int i = 1; i < k; i++) push(32'h3000 + 32'(i*4), (i % 2 == 0) ? 2'd3 : 2'd0, 1, 0, 0, 0);
            push(32'h3100, 2'd2, 0, 0, 0, 0);
        end

        // R3, R4, R5: walk one counter up, across saturation, and back down
        probe(HB, 1);
        upd(HB, 1); probe(HB, 0);
        upd(HB, 1); probe(HB, 1);
        probe(HB + 32'h1000, 1);   // R4 aliases through bit 12
        probe(HB + 32'h4, 1);      // R4 neighbouring word is separate
        for (int i = 0; i < 3; i++) begin upd(HB, 1); probe(HB, 1); end
        for (int i = 0; i < 5; i++) begin upd(HB, 0); probe(HB, 0); end
        upd(HB, 1); upd(HB, 1);

        // R7: learned lengths 0..17 with indirect and hard branches inside
        for (int ml = 0; ml <= 17; ml++) begin
            int i;
            i = 0;
            do begin
                push((i % 4 == 1) ? HB : 32'h6000 + 32'(i*4),
                     (i == 0) ? 2'd0 : 2'(i % 4), i[0], 1, 5'(ml), 2'(ml));
                i++;
            end while (m_open);
        end

        // R9: mixed branches with varied directions
        for (int i = 0; i < 12; i++)
            push(32'h5000_0000 + 32'(i*4), (i % 3 == 0) ? 2'd1 : ((i % 3 == 1) ? 2'd3 : 2'd0),
                 ((i * 7) % 5) < 2, 0, 0, 0);
        push(32'h5000_0100, 2'd2, 0, 0, 0, 0);

        // R8: back-to-back single micro-op blocks
        push(32'h7000, 2'd2, 0, 0, 0, 0);
        push(32'h7004, 2'd0, 0, 1, 5'd1, 2'd2);
        push(32'h7008, 2'd2, 0, 0, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule